// File: doc/BRIEF.md
# Shadow Clock Phase Calibration Sequencer

This block runs an offline calibration of a shadow-register timing detector. It drives an external phase-adjustable clock source through a one-step-at-a-time handshake. The detector's own mismatch output serves as the measuring instrument. Starting from zero offset, the block first delays the shadow clock one step at a time until a mismatch shows up. That count of steps is the hold slack. It then walks the phase back to zero. Next it advances the shadow clock the same way until a mismatch appears, and converts the number of steps into a setup delay by subtracting it from the clock period, expressed in phase steps. Finally it walks the phase back to zero again.

At each phase point the sequencer waits for the clock source to acknowledge the step. It then lets a programmable settle time pass and watches the mismatch line for a programmable window of cycles. The run is meant for a known, fixed main clock frequency before the detectors go into normal service. A programmable guard margin is taken off the measured hold slack to give the largest shadow lag that software may then program.

Top module: `phase_cal_seq`

## Requirements
- R1: After reset, `busy`, `done` and `ph_step` are 0, and `hold_slack`, `setup_delay`, `op_lag`, `hold_noedge` and `setup_noedge` are all 0.
- R2: The first sweep issues steps with `ph_dir`=1 (shadow lag increases by one step each time). It stops after the first observation window that contains a mismatch, and `hold_slack` holds the number of lag steps taken.
- R3: The second sweep issues steps with `ph_dir`=0 (shadow clock advances by one step each time). It stops at the first window with a mismatch, and `setup_delay` = `cfg_period` − steps advanced, saturated at 0.
- R4: Each step is a `ph_step` pulse lasting one cycle. The sequencer then waits for `ph_done`. Counting from the cycle in which `ph_done` is sampled high, it spends `cfg_settle`+1 settle cycles and then max(`cfg_window`,1) observe cycles. During a sweep without a hit, the next `ph_step` therefore comes `cfg_settle`+max(`cfg_window`,1)+2 cycles after that acknowledge cycle.
- R5: A mismatch high for even a single cycle inside the observation window counts as a hit. A mismatch outside observation windows (for example while a step acknowledge is pending) has no effect.
- R6: If a sweep reaches `cfg_max_steps` steps without a hit, it stops, records `cfg_max_steps` as its step count and sets its no-edge flag (`hold_noedge` or `setup_noedge`). Otherwise that flag is 0.
- R7: After each sweep the sequencer issues exactly as many steps in the opposite direction, so the net phase offset is zero when `done` rises.
- R8: `op_lag` = `hold_slack` − `cfg_guard`, saturated at 0.
- R9: `start` while idle clears all results and `done`, and sets `busy` from the next cycle. When the second return to zero completes, `busy` falls and `done` rises and stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (honoured when idle) |
| cfg_window | input | CNT_W | Observation window length in cycles (0 acts as 1) |
| cfg_settle | input | CNT_W | Extra settle cycles after a step acknowledge |
| cfg_max_steps | input | STEP_W | Sweep limit in phase steps |
| cfg_guard | input | STEP_W | Guard margin subtracted from hold slack |
| cfg_period | input | STEP_W | Main clock period in phase steps |
| mismatch | input | 1 | Discrepancy output of the detector under test |
| ph_done | input | 1 | Clock source acknowledges the last step |
| ph_step | output | 1 | One-cycle step request to the clock source |
| ph_dir | output | 1 | Step direction: 1 adds lag, 0 advances |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | Run complete, results valid |
| hold_slack | output | STEP_W | Measured hold slack in steps |
| setup_delay | output | STEP_W | Measured setup delay in steps |
| op_lag | output | STEP_W | Permitted operating lag |
| hold_noedge | output | 1 | Lag sweep hit its limit without a mismatch |
| setup_noedge | output | 1 | Advance sweep hit its limit without a mismatch |

## Verification
The main function is exercised by a modelled detector that fails beyond a lag edge and beyond an advance edge placed at different distances. Some runs drive a continuous mismatch. Others drive only one pulse every four cycles, which separates "any cycle in the window" from "the last cycle of the window". Others drive spurious pulses while an acknowledge is pending, which shows whether stray mismatches leak into the result. Edges placed beyond the step limit show the no-edge paths apart from real edges. Small clock periods and large guard margins drive both saturations. The phase source model tracks the net offset and the deepest point reached in each direction, which shows both that each sweep stopped at the first hit and that the block returned to zero.

// File: rtl/phase_cal_pkg.sv
package phase_cal_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_STEP,
    S_ACK,
    S_SETTLE,
    S_OBS
  } seq_state_t;

  // sweep phase: lag sweep, return from lag, advance sweep, return from advance
  typedef enum logic [1:0] {
    M_LAG,
    M_LAG_RET,
    M_ADV,
    M_ADV_RET
  } sweep_mode_t;
endpackage

// File: rtl/phase_cal_timer.sv
module phase_cal_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/phase_cal_result.sv
module phase_cal_result #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lag,
  input  logic              wr_adv,
  input  logic              noedge,
  input  logic [STEP_W-1:0] steps,
  input  logic [STEP_W-1:0] period,
  input  logic [STEP_W-1:0] guard,
  output logic [STEP_W-1:0] hold_slack,
  output logic [STEP_W-1:0] setup_delay,
  output logic [STEP_W-1:0] op_lag,
  output logic              hold_noedge,
  output logic              setup_noedge
);
  logic [STEP_W-1:0] hold_q, setup_q;
  logic              hne_q, sne_q;
  logic [STEP_W-1:0] setup_calc;

  assign setup_calc = (period > steps) ? (period - steps) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      setup_q <= '0;
      hne_q   <= 1'b0;
      sne_q   <= 1'b0;
    end else if (clr) begin
      hold_q  <= '0;
      setup_q <= '0;
      hne_q   <= 1'b0;
      sne_q   <= 1'b0;
    end else begin
      if (wr_lag) begin
        hold_q <= steps;
        hne_q  <= noedge;
      end
      if (wr_adv) begin
        setup_q <= setup_calc;
        sne_q   <= noedge;
      end
    end
  end

  assign hold_slack   = hold_q;
  assign setup_delay  = setup_q;
  assign hold_noedge  = hne_q;
  assign setup_noedge = sne_q;
  assign op_lag       = (hold_q > guard) ? (hold_q - guard) : '0;
endmodule

// File: rtl/phase_cal_seq.sv
module phase_cal_seq
  import phase_cal_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_window,
  input  logic [CNT_W-1:0]  cfg_settle,
  input  logic [STEP_W-1:0] cfg_max_steps,
  input  logic [STEP_W-1:0] cfg_guard,
  input  logic [STEP_W-1:0] cfg_period,
  input  logic              mismatch,
  input  logic              ph_done,
  output logic              ph_step,
  output logic              ph_dir,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] hold_slack,
  output logic [STEP_W-1:0] setup_delay,
  output logic [STEP_W-1:0] op_lag,
  output logic              hold_noedge,
  output logic              setup_noedge
);
  localparam logic [STEP_W-1:0] ONE_STEP = STEP_W'(1);

  seq_state_t        st_q, st_d;
  sweep_mode_t       mode_q, mode_d;
  logic [STEP_W-1:0] pos_q, pos_d;
  logic              hit_q, hit_d;
  logic              done_q, done_d;

  logic              tmr_clr, tmr_en, tmr_exp;
  logic [CNT_W-1:0]  win_last, tmr_limit;
  logic              res_clr, wr_lag, wr_adv;
  logic              obs_hit, sweeping;

  assign win_last  = (cfg_window == '0) ? '0 : (cfg_window - 1'b1);
  assign tmr_limit = (st_q == S_SETTLE) ? cfg_settle : win_last;
  assign obs_hit   = hit_q | mismatch;
  assign sweeping  = (mode_q == M_LAG) || (mode_q == M_ADV);

  // next-state process
  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    pos_d   = pos_q;
    hit_d   = hit_q;
    done_d  = done_q;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    res_clr = 1'b0;
    wr_lag  = 1'b0;
    wr_adv  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          res_clr = 1'b1;
          done_d  = 1'b0;
          mode_d  = M_LAG;
          pos_d   = '0;
          st_d    = S_STEP;
        end
      end
      S_STEP: st_d = S_ACK;
      S_ACK: begin
        if (ph_done) begin
          if (sweeping) begin
            pos_d   = pos_q + ONE_STEP;
            tmr_clr = 1'b1;
            st_d    = S_SETTLE;
          end else begin
            pos_d = pos_q - ONE_STEP;
            if (pos_q == ONE_STEP) begin
              if (mode_q == M_LAG_RET) begin
                mode_d = M_ADV;
                st_d   = S_STEP;
              end else begin
                done_d = 1'b1;
                st_d   = S_IDLE;
              end
            end else begin
              st_d = S_STEP;
            end
          end
        end
      end
      S_SETTLE: begin
        if (tmr_exp) begin
          tmr_clr = 1'b1;
          hit_d   = 1'b0;
          st_d    = S_OBS;
        end else begin
          tmr_en = 1'b1;
        end
      end
      S_OBS: begin
        hit_d = obs_hit;
        if (tmr_exp) begin
          st_d = S_STEP;
          if (obs_hit || (pos_q >= cfg_max_steps)) begin
            wr_lag = (mode_q == M_LAG);
            wr_adv = (mode_q == M_ADV);
            mode_d = (mode_q == M_LAG) ? M_LAG_RET : M_ADV_RET;
          end
        end else begin
          tmr_en = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      mode_q <= M_LAG;
      pos_q  <= '0;
      hit_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      pos_q  <= pos_d;
      hit_q  <= hit_d;
      done_q <= done_d;
    end
  end

  phase_cal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .limit   (tmr_limit),
    .expired (tmr_exp)
  );

  phase_cal_result #(.STEP_W(STEP_W)) u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (res_clr),
    .wr_lag       (wr_lag),
    .wr_adv       (wr_adv),
    .noedge       (~obs_hit),
    .steps        (pos_q),
    .period       (cfg_period),
    .guard        (cfg_guard),
    .hold_slack   (hold_slack),
    .setup_delay  (setup_delay),
    .op_lag       (op_lag),
    .hold_noedge  (hold_noedge),
    .setup_noedge (setup_noedge)
  );

  assign ph_step = (st_q == S_STEP);
  assign ph_dir  = (mode_q == M_LAG) || (mode_q == M_ADV_RET);
  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/phase_cal_seq_chk.sv
module phase_cal_seq_chk #(
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ph_step,
  input logic              busy,
  input logic              done,
  input logic [STEP_W-1:0] cfg_guard,
  input logic [STEP_W-1:0] cfg_max_steps,
  input logic [STEP_W-1:0] hold_slack,
  input logic [STEP_W-1:0] op_lag
);
  // R4: a step request never lasts longer than one cycle
  a_r4_step_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ph_step |=> !ph_step);

  // R1: no step requests while idle
  a_r1_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ph_step);

  // R9: done and busy are never high together
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: start while idle makes the block busy and clears done
  a_r9_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R9: done only rises at the end of a run
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R8: operating lag never exceeds the hold slack
  a_r8_lag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    op_lag <= hold_slack);

  // R8: with a nonzero guard the lag stays strictly below the hold slack
  a_r8_lag_below: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_guard != '0) && (hold_slack != '0)) |-> (op_lag < hold_slack));

  // R6: the lag sweep result never passes the step limit
  a_r6_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (hold_slack <= cfg_max_steps));
endmodule

bind phase_cal_seq phase_cal_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .ph_step       (ph_step),
  .busy          (busy),
  .done          (done),
  .cfg_guard     (cfg_guard),
  .cfg_max_steps (cfg_max_steps),
  .hold_slack    (hold_slack),
  .op_lag        (op_lag)
);

// File: tb/phase_cal_seq_bench.sv
module phase_cal_seq_bench;
  localparam int STEP_W = 8;
  localparam int CNT_W  = 16;
  localparam int ACKD   = 2;

  typedef struct packed {
    logic [7:0] he;      // lag edge: mismatch when lag >= he
    logic [7:0] se;      // advance edge: mismatch when advance >= se
    logic [7:0] win;
    logic [7:0] settle;
    logic [7:0] maxs;
    logic [7:0] guard;
    logic [7:0] period;
    logic       sparse;  // mismatch only every 4th cycle
    logic       glitch;  // stray mismatch while an ack is pending
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd5,  8'd7,  8'd8, 8'd2, 8'd20, 8'd2, 8'd40, 1'b0, 1'b0},
    '{8'd3,  8'd9,  8'd8, 8'd0, 8'd20, 8'd1, 8'd30, 1'b1, 1'b1},
    '{8'd30, 8'd4,  8'd4, 8'd1, 8'd10, 8'd2, 8'd30, 1'b0, 1'b0},
    '{8'd6,  8'd30, 8'd5, 8'd3, 8'd12, 8'd8, 8'd20, 1'b1, 1'b0},
    '{8'd2,  8'd25, 8'd0, 8'd0, 8'd30, 8'd0, 8'd16, 1'b0, 1'b1}
  };

  logic clk, rst_n, start, mismatch, ph_done;
  logic [CNT_W-1:0]  cfg_window, cfg_settle;
  logic [STEP_W-1:0] cfg_max_steps, cfg_guard, cfg_period;
  logic ph_step, ph_dir, busy, done, hold_noedge, setup_noedge;
  logic [STEP_W-1:0] hold_slack, setup_delay, op_lag;

  int checks = 0, errors = 0;
  int cyc = 0;
  int pos = 0, peak_lag = 0, peak_adv = 0;
  int pend = 0, pdir = 0;
  int gap_st = 0, t_ack = 0, gap = 0;
  int he_m = 255, se_m = 255;
  logic sparse_m = 1'b0, glitch_m = 1'b0;

  phase_cal_seq #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_phase_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_window(cfg_window), .cfg_settle(cfg_settle),
    .cfg_max_steps(cfg_max_steps), .cfg_guard(cfg_guard), .cfg_period(cfg_period),
    .mismatch(mismatch), .ph_done(ph_done),
    .ph_step(ph_step), .ph_dir(ph_dir), .busy(busy), .done(done),
    .hold_slack(hold_slack), .setup_delay(setup_delay), .op_lag(op_lag),
    .hold_noedge(hold_noedge), .setup_noedge(setup_noedge)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // phase source and detector model
  initial begin
    ph_done  = 1'b0;
    mismatch = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      ph_done = 1'b0;
      if (!rst_n) begin
        pend = 0;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          ph_done = 1'b1;
          pos += (pdir != 0) ? 1 : -1;
          if (pos > peak_lag)  peak_lag = pos;
          if (-pos > peak_adv) peak_adv = -pos;
          if (gap_st == 0) begin
            t_ack  = cyc;
            gap_st = 1;
          end
        end
      end else if (ph_step) begin
        pend = ACKD;
        pdir = int'(ph_dir);
        if (gap_st == 1) begin
          gap    = cyc - t_ack;
          gap_st = 2;
        end
      end
      mismatch = (((pos >= he_m) || (-pos >= se_m)) && (!sparse_m || (cyc % 4 == 0)))
                 || (glitch_m && (pend > 0));
    end
  end

  task automatic launch();
    pos = 0; peak_lag = 0; peak_adv = 0; gap_st = 0; gap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic load(input vec_t v);
    cfg_window    = CNT_W'(v.win);
    cfg_settle    = CNT_W'(v.settle);
    cfg_max_steps = v.maxs;
    cfg_guard     = v.guard;
    cfg_period    = v.period;
    he_m = int'(v.he); se_m = int'(v.se);
    sparse_m = v.sparse; glitch_m = v.glitch;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    load(VECS[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ph_step", int'(ph_step), 0);
    chk("R1 hold_slack", int'(hold_slack), 0);
    chk("R1 setup_delay", int'(setup_delay), 0);
    chk("R1 op_lag", int'(op_lag), 0);
    chk("R1 flags", int'({hold_noedge, setup_noedge}), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      int eh, es, w1;
      load(VECS[i]);
      eh = (int'(VECS[i].he) > int'(VECS[i].maxs)) ? int'(VECS[i].maxs) : int'(VECS[i].he);
      es = (int'(VECS[i].se) > int'(VECS[i].maxs)) ? int'(VECS[i].maxs) : int'(VECS[i].se);
      w1 = (VECS[i].win == 8'd0) ? 1 : int'(VECS[i].win);
      launch();
      // R9 start clears done and raises busy
      chk("R9 busy after start", int'(busy), 1);
      chk("R9 done cleared", int'(done), 0);
      wait_done();
      chk("R9 busy at end", int'(busy), 0);
      chk("R2 hold_slack", int'(hold_slack), eh);
      chk("R2 R5 lag stop point", peak_lag, eh);
      chk("R3 setup_delay", int'(setup_delay),
          (int'(VECS[i].period) > es) ? int'(VECS[i].period) - es : 0);
      chk("R3 R5 advance stop point", peak_adv, es);
      chk("R6 hold_noedge", int'(hold_noedge), int'(VECS[i].he > VECS[i].maxs));
      chk("R6 setup_noedge", int'(setup_noedge), int'(VECS[i].se > VECS[i].maxs));
      chk("R7 net phase zero", pos, 0);
      chk("R8 op_lag", int'(op_lag),
          (eh > int'(VECS[i].guard)) ? eh - int'(VECS[i].guard) : 0);
      chk("R4 step spacing", gap, int'(VECS[i].settle) + w1 + 2);
      repeat (3) @(negedge clk);
      chk("R9 done held", int'(done), 1);
    end

    // directed: reset in the middle of a run
    load(VECS[0]);
    launch();
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy under reset", int'(busy), 0);
    chk("R1 done under reset", int'(done), 0);
    chk("R1 hold under reset", int'(hold_slack), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: step limit of one with edge beyond it
    load('{8'd9, 8'd9, 8'd4, 8'd0, 8'd1, 8'd0, 8'd3, 1'b0, 1'b0});
    launch();
    wait_done();
    chk("R6 limit one hold", int'(hold_slack), 1);
    chk("R6 limit one flags", int'({hold_noedge, setup_noedge}), 3);
    chk("R3 limit one setup", int'(setup_delay), 2);
    chk("R7 limit one zero", pos, 0);

    // directed: mismatch only while acks pend, no real edge
    load('{8'd200, 8'd200, 8'd3, 8'd1, 8'd4, 8'd1, 8'd10, 1'b0, 1'b1});
    launch();
    wait_done();
    chk("R5 stray mismatch ignored", int'(hold_noedge), 1);
    chk("R5 stray mismatch hold", int'(hold_slack), 4);
    chk("R8 lag after limit", int'(op_lag), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule